// File: doc/BRIEF.md
# Two-Phase LCD Multiplex Frame Generator

This block sequences the drive of a liquid crystal panel that has two backplanes, with each pixel made of two segments. A 2-bit phase counter runs on the multiplex clock. Its low bit is the backplane-select phase, which runs at half the clock rate. Its high bit is the AC-inversion phase, which runs at a quarter of the clock rate.

For every segment line, the block presents one of the two latched data bits, chosen by the select phase. It inverts that bit while the inversion phase is high, so the panel sees no net DC component over a full frame. The block also issues a 2-bit level code for each backplane, and a downstream analog driver turns each code into VSS, VDD/2 or VDD.

The block sits between a latched display data register and the pad drivers. Loading new data takes effect on the segment outputs at once, because the segment path is combinational from the data input and the registered phase.

Top module: `lcd_mux_frame_gen`

## Requirements
- R1: While rst_ni is low, and after it is released until the first rising clk_i edge, the phase is 0. In phase 0, com1_o = 2'b10, com2_o = 2'b01 and each seg_o[n] equals data_i[2n].
- R2: The select phase toggles on every rising clk_i edge, so the phase sequence runs 0,1,2,3,0,...
- R3: The inversion phase toggles on every second rising clk_i edge, namely on the edges that leave a phase with select = 1. This gives a four-edge frame.
- R4: With select = 0, seg_o[n] is derived from data_i[2n] (bit n_1). With select = 1, seg_o[n] is derived from data_i[2n+1] (bit n_2). This holds for n = 0 to N_SEG-1.
- R5: With inversion = 1, every segment output is the complement of its selected bit. With inversion = 0, it is the selected bit unchanged.
- R6: The backplane codes use 2'b00 = VSS, 2'b01 = VMID and 2'b10 = VDD. Code 2'b11 never appears.
- R7: com1_o is the active backplane while select = 0, and com2_o is the active backplane while select = 1. The active backplane is at VDD when inversion = 0 and at VSS when inversion = 1.
- R8: The inactive backplane sits at VMID, so exactly one of the two codes is VMID at any time.
- R9: Asserting rst_ni low in the middle of a frame returns the block to phase 0 at once, and counting restarts from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Multiplex clock; the phase advances on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | 2*N_SEG | Latched data; bit 2n is segment n on backplane 1, bit 2n+1 is segment n on backplane 2 |
| seg_o | output | N_SEG | Segment drive bits |
| com1_o | output | 2 | Level code for backplane 1 |
| com2_o | output | 2 | Level code for backplane 2 |

## Verification
The bench walks several full frames with fresh random data at every phase. If the design swapped the select polarity, odd and even data bits would trade places. If it inverted on the wrong phase, whole frames would come out complemented. A divider chained the wrong way would show up as a broken phase sequence on the backplane codes. Uniform all-ones and all-zeros patterns expose a stuck inversion. A reset in the middle of a frame catches a counter that does not clear asynchronously or that restarts from a stale phase.

// File: rtl/lcd_mux_pkg.sv
package lcd_mux_pkg;
  typedef enum logic [1:0] {
    LVL_VSS  = 2'b00,
    LVL_VMID = 2'b01,
    LVL_VDD  = 2'b10
  } bp_level_e;
endpackage

// File: rtl/lcd_phase_div.sv
module lcd_phase_div (
  input  logic clk_i,
  input  logic rst_ni,
  output logic sel_o,
  output logic inv_o
);
  logic [1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 2'b00;
    else         phase_q <= phase_q + 2'd1;
  end

  assign sel_o = phase_q[0];
  assign inv_o = phase_q[1];

  AST_SEL_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (sel_o != $past(sel_o)));                           // R2
  AST_INV_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o |=> (inv_o != $past(inv_o)));                          // R3
  AST_INV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_o |=> $stable(inv_o));                                  // R3
endmodule

// File: rtl/lcd_seg_mux.sv
module lcd_seg_mux #(
  parameter int N_SEG = 140,
  localparam int DW = 2 * N_SEG
) (
  input  logic [DW-1:0]    data_i,
  input  logic             sel_i,
  input  logic             inv_i,
  output logic [N_SEG-1:0] seg_o
);
  for (genvar n = 0; n < N_SEG; n++) begin : g_seg
    logic pick;
    assign pick     = sel_i ? data_i[2*n+1] : data_i[2*n];
    assign seg_o[n] = pick ^ inv_i;
  end
endmodule

// File: rtl/lcd_bp_encode.sv
module lcd_bp_encode
  import lcd_mux_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sel_i,
  input  logic      inv_i,
  output bp_level_e com1_o,
  output bp_level_e com2_o
);
  bp_level_e active;

  always_comb begin
    active = inv_i ? LVL_VSS : LVL_VDD;
    com1_o = sel_i ? LVL_VMID : active;
    com2_o = sel_i ? active : LVL_VMID;
  end

  AST_ONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((com1_o == LVL_VMID) != (com2_o == LVL_VMID)));             // R8
  AST_NO_BAD_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (com1_o != 2'b11) && (com2_o != 2'b11));                     // R6
endmodule

// File: rtl/lcd_mux_frame_gen.sv
module lcd_mux_frame_gen
  import lcd_mux_pkg::*;
#(
  parameter int N_SEG = 140,
  localparam int DW = 2 * N_SEG
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DW-1:0]    data_i,
  output logic [N_SEG-1:0] seg_o,
  output logic [1:0]       com1_o,
  output logic [1:0]       com2_o
);
  logic      sel, inv;
  bp_level_e com1, com2;

  lcd_phase_div u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_o (sel),
    .inv_o (inv)
  );

  lcd_seg_mux #(.N_SEG(N_SEG)) u_mux (
    .data_i(data_i),
    .sel_i (sel),
    .inv_i (inv),
    .seg_o (seg_o)
  );

  lcd_bp_encode u_bp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (sel),
    .inv_i (inv),
    .com1_o(com1),
    .com2_o(com2)
  );

  assign com1_o = com1;
  assign com2_o = com2;
endmodule

// File: tb/lcd_mux_frame_gen_bench.sv
module lcd_mux_frame_gen_bench;
  localparam int N_SEG = 140;
  localparam int DW = 2 * N_SEG;

  // phase -> {com1, com2}
  localparam logic [3:0] BP_TAB [4] = '{4'b10_01, 4'b01_10, 4'b00_01, 4'b01_00};

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [DW-1:0]    data_i = '0;
  logic [N_SEG-1:0] seg_o;
  logic [1:0]       com1_o, com2_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  lcd_mux_frame_gen #(.N_SEG(N_SEG)) u_lcd_mux_frame_gen (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .data_i(data_i),
    .seg_o (seg_o),
    .com1_o(com1_o),
    .com2_o(com2_o)
  );

  always #10 clk_i = ~clk_i;

  function automatic logic [N_SEG-1:0] exp_seg(logic [DW-1:0] d, int p);
    logic [N_SEG-1:0] r;
    for (int n = 0; n < N_SEG; n++)
      r[n] = ((p % 2) != 0 ? d[2*n+1] : d[2*n]) ^ (((p / 2) % 2) != 0);
    return r;
  endfunction

  task automatic fill_rand();
    for (int k = 0; k < DW; k += 32) begin
      logic [31:0] w;
      w = $urandom;
      for (int b = 0; b < 32; b++) if (k + b < DW) data_i[k+b] = w[b];
    end
  endtask

  task automatic check_phase(int p, string tag);
    logic [N_SEG-1:0] e;
    logic [3:0] bp;
    e  = exp_seg(data_i, p);
    bp = BP_TAB[p % 4];
    checks++;
    if (seg_o !== e) begin
      errors++;
      $display("FAIL %s R4 R5 phase %0d seg act %h exp %h", tag, p % 4, seg_o, e);
    end
    checks++;
    if (com1_o !== bp[3:2] || com2_o !== bp[1:0]) begin
      errors++;
      $display("FAIL %s R2 R3 R7 R8 phase %0d com act %b/%b exp %b/%b",
               tag, p % 4, com1_o, com2_o, bp[3:2], bp[1:0]);
    end
    checks++;
    if (com1_o == 2'b11 || com2_o == 2'b11) begin
      errors++;
      $display("FAIL %s R6 illegal code act %b/%b exp not 11", tag, com1_o, com2_o);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired act running exp finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int p;
    // R1: reset state
    repeat (3) @(negedge clk_i);
    fill_rand();
    #2 check_phase(0, "R1 in reset");
    rst_ni = 1'b1;
    #2 check_phase(0, "R1 after release");
    p = 0;
    // main sweep: random data each phase over several frames
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_i);
      p++;
      fill_rand();
      #2 check_phase(p, "sweep");
    end
    // uniform patterns expose stuck inversion (R5)
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      p++;
      data_i = '1;
      #2 check_phase(p, "ones R5");
      data_i = '0;
      #1 check_phase(p, "zeros R5");
    end
    // R9: reset in mid frame
    @(negedge clk_i);
    p++;
    if ((p % 4) == 0) begin
      @(negedge clk_i);
      p++;
    end
    fill_rand();
    #2 check_phase(p, "pre reset");
    rst_ni = 1'b0;
    #2 check_phase(0, "R9 reset mid frame");
    @(negedge clk_i);
    rst_ni = 1'b1;
    p = 0;
    #2 check_phase(p, "R9 release");
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      p++;
      fill_rand();
      #2 check_phase(p, "R9 restart");
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule